// File: doc/BRIEF.md
# Single-Bank SDRAM Access Sequencer

This block sits on the controller side of an SDRAM interface. It serves one read or one write at a time. Each access goes to one bank and runs a fixed three-command sequence: open the row, issue the column read or write as a four-beat burst, then close the row with an explicit precharge. Every gap between commands is a module parameter counted in clocks. Idle cycles carry a no-operation command. The block never leaves a row open between accesses.

The user side hands over a bank, a row, a column, a write flag and the four write words in a single transfer. The transfer completes on a clock where both `req_valid` and `ready` are high. Read words come back one per clock, each marked by `rd_valid`. The capture point follows a CAS latency of 2 or 3, picked with `cl_sel3`. `ready` stays low until three things hold: the previous access has fully closed, the row-cycle time since the last activate has passed, and every read beat in flight has been captured. A read followed at once by a write to the same bank therefore never collides on the data bus.

Top module: `sdr_bank_seq`

## Requirements
- R1: The command lines {cs_n, ras_n, cas_n, we_n} carry only these codes: activate 0011, read 0101, write 0100, precharge 0010 and no-operation 0111. No-operation is driven on every cycle without a command. `sd_cke` is always 1 and `sd_dqm` is always 0.
- R2: Each accepted request produces, in this order, one activate, one column command of the requested kind and one precharge. `sd_ba` equals the requested bank on all three commands, and `sd_addr` equals the row on the activate.
- R3: The column command comes exactly T_RCD cycles after its activate. On it, `sd_addr[COL_W-1:0]` carries the column and address bit 10 is 0.
- R4: The precharge drives address bit 10 low, so it closes only the selected bank. After a read, the precharge comes exactly BURST cycles after the read command.
- R5: After a write, the precharge comes exactly BURST-1+T_RDL cycles after the write command, which is T_RDL cycles after the last write beat.
- R6: `sd_dq_oe` is 1 only during the BURST cycles that start with the write command. In the cycle that is beat i of those (i counted from 0), `sd_dq_out` equals `req_wdata[16*i +: 16]`.
- R7: With CAS latency L (L=2 when `cl_sel3`=0, L=3 when it is 1), the word on `sd_dq_in` in the cycle L+i after a read command is presented on `rd_data` with `rd_valid`=1 one cycle later, for i = 0..BURST-1. `rd_valid` is never high at any other time.
- R8: A request is accepted on a clock where `req_valid` and `ready` are both 1, and its activate appears in the very next cycle. `ready` is 0 while an access is in progress or read beats are still arriving.
- R9: Two activates are at least T_RC cycles apart. When requests arrive back to back, the gap after a write is max(T_RC, T_RCD+BURST+T_RDL+1). After a read it is max(T_RC, T_RCD+BURST+2, T_RCD+L+BURST+1).
- R10: After reset the command is no-operation, `ready` is 1, and both `sd_dq_oe` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cl_sel3 | input | 1 | CAS latency select: 0 for 2, 1 for 3 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_wdata | input | BURST*DQ_W | Write words, beat 0 in the low bits |
| ready | output | 1 | Request can be accepted this cycle |
| rd_data | output | DQ_W | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address; bit 10 is the precharge-scope bit |
| sd_dqm | output | DQ_W/8 | Byte masks, held low |
| sd_dq_out | output | DQ_W | Write data to the bus |
| sd_dq_oe | output | 1 | Bus output enable |
| sd_dq_in | input | DQ_W | Read data from the bus |

## Verification
The assertions assume four things about the inputs:
- The request fields stay constant while `req_valid` waits for `ready`.
- `cl_sel3` changes only while the block is idle with no read beats pending.
- The memory drives `sd_dq_in` only during the cycles its latency dictates.
- The parameters satisfy T_RCD ≥ 2, T_RDL ≥ 1 and a column width of at most 10 bits.

The stimulus respects all four. It holds each request until it is accepted. It changes the latency only after a long idle pause between chains of requests. Its memory model places each read word on the bus exactly L+i cycles after the read command it observes.

// File: rtl/sdr_seq_pkg.sv
// Shared types for the single-bank SDRAM access sequencer.
// Command codes are packed as {cs_n, ras_n, cas_n, we_n}.
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_COL,
        ST_TAIL,
        ST_PRE
    } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
// Minimum-interval timer.
// Loading on `start` makes `done` go low and stay low for LIMIT-1 cycles,
// counting the cycle right after the start.
// Assumes LIMIT >= 1. Reset leaves the timer expired.
module sdr_gap_timer #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(LIMIT - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdr_rd_capture.sv
// Read-beat capture.
// `beat_in` is high during each cycle that stands for a read beat, aligned
// with the read command. The flag goes through a short shift line and picks
// tap 2 or tap 3, so bus data is sampled L cycles after each beat flag and
// shown one cycle later. `busy` stays high while any beat is still pending.
// Assumes cl3 is constant while busy.
module sdr_rd_capture #(
    parameter int DQ_W  = 16,
    parameter int BURST = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_in,
    input  logic            cl3,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_valid,
    output logic            busy
);
    localparam int MAX_CL = 3;
    localparam int RUN_W  = $clog2(BURST + 1);

    logic [MAX_CL:1] pipe;
    logic            hit;

    // Delay line of beat flags, one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[MAX_CL-1:1], beat_in};
        end
    end

    assign hit = cl3 ? pipe[3] : pipe[2];

    // Sample the bus on the latency-selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= hit;
            if (hit) begin
                rd_data <= dq_in;
            end
        end
    end

    assign busy = beat_in | pipe[1] | pipe[2] | (cl3 & pipe[3]);

    // Checker state: length of the current run of valid beats.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (rd_valid) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_RD_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (run_len < RUN_W'(BURST)));  // R7

endmodule

// File: rtl/sdr_seq_ctrl.sv
// Command sequencer for one access:
//   activate -> wait -> column read/write -> tail wait -> precharge -> idle.
// Outputs are decoded from registered state, so each command holds for
// exactly one cycle.
// Write words are latched at accept and driven on the bus starting with the
// write command.
// Assumes T_RCD >= 2, T_RDL >= 1, BURST >= 2, COL_W <= 10 < ROW_W.
module sdr_seq_ctrl
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int DQ_W   = 16,
    parameter int BURST  = 4,
    parameter int T_RCD  = 2,
    parameter int T_RDL  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  req_write,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic [BURST*DQ_W-1:0] req_wdata,
    output sdr_cmd_e              cmd,
    output logic [ROW_W-1:0]      addr,
    output logic [BANK_W-1:0]     ba,
    output logic [DQ_W-1:0]       dq_out,
    output logic                  dq_oe,
    output logic                  rd_beat,
    output logic                  idle
);
    localparam int AP_BIT  = 10;
    localparam int IDX_W   = $clog2(BURST);
    localparam int TAIL_RD = BURST - 1;
    localparam int TAIL_WR = BURST - 2 + T_RDL;
    localparam int CNT_W   = $clog2(BURST + T_RDL + T_RCD + 2);
    localparam int AGE_MAX = T_RCD + BURST + T_RDL + 2;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);

    seq_state_e              state;
    logic [CNT_W-1:0]        cnt;
    logic [IDX_W-1:0]        beat_left;
    logic                    wr_q;
    logic [BANK_W-1:0]       bank_q;
    logic [ROW_W-1:0]        row_q;
    logic [COL_W-1:0]        col_q;
    logic [BURST*DQ_W-1:0]   wdata_q;
    logic                    beat_on;
    logic [IDX_W-1:0]        beat_idx;

    // Step through the access and latch the request at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            beat_left <= '0;
            wr_q      <= 1'b0;
            bank_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
            wdata_q   <= '0;
        end else begin
            if (state != ST_COL && beat_left != '0) begin
                beat_left <= beat_left - 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_ACT;
                        wr_q    <= req_write;
                        bank_q  <= req_bank;
                        row_q   <= req_row;
                        col_q   <= req_col;
                        wdata_q <= req_wdata;
                    end
                end
                ST_ACT: begin
                    state <= ST_RCD;
                    cnt   <= CNT_W'(T_RCD - 1);
                end
                ST_RCD: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_COL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    state     <= ST_TAIL;
                    cnt       <= wr_q ? CNT_W'(TAIL_WR) : CNT_W'(TAIL_RD);
                    beat_left <= IDX_W'(BURST - 1);
                end
                ST_TAIL: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode the bus command and address from the current state.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        case (state)
            ST_ACT: begin
                cmd  = CMD_ACT;
                addr = row_q;
            end
            ST_COL: begin
                cmd               = wr_q ? CMD_WR : CMD_RD;
                addr[COL_W-1:0]   = col_q;
                addr[AP_BIT]      = 1'b0;
            end
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b0;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

    // Beat window: the column cycle plus BURST-1 more.
    always_comb begin
        beat_on  = (state == ST_COL) || (beat_left != '0);
        beat_idx = (beat_left == '0) ? '0 : IDX_W'(BURST - int'(beat_left));
    end

    assign ba      = bank_q;
    assign dq_out  = wdata_q[beat_idx*DQ_W +: DQ_W];
    assign dq_oe   = beat_on & wr_q;
    assign rd_beat = beat_on & ~wr_q;
    assign idle    = (state == ST_IDLE);

    // Checker state: cycles since the last activate and the last column command.
    logic [AGE_W-1:0] act_age;
    logic [AGE_W-1:0] col_age;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_age <= '0;
            col_age <= '0;
        end else begin
            if (cmd == CMD_ACT) begin
                act_age <= AGE_W'(1);
            end else if (act_age != AGE_W'(AGE_MAX)) begin
                act_age <= act_age + 1'b1;
            end
            if (cmd == CMD_RD || cmd == CMD_WR) begin
                col_age <= AGE_W'(1);
            end else if (col_age != AGE_W'(AGE_MAX)) begin
                col_age <= col_age + 1'b1;
            end
        end
    end

    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (act_age == AGE_W'(T_RCD)));  // R3

    AST_RDL_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && wr_q) |-> (col_age == AGE_W'(BURST - 1 + T_RDL)));  // R5

    AST_RD_PRE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && !wr_q) |-> (col_age == AGE_W'(BURST)));  // R4

    AST_OE_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (cmd == CMD_WR));  // R6

endmodule

// File: rtl/sdr_bank_seq.sv
// Top of the single-bank SDRAM access sequencer.
// Combines the command sequencer, the row-cycle timer and the read capture.
// `ready` is high only when the sequencer is idle, T_RC has passed since the
// last activate, and no read beats are pending.
// Assumes request fields are stable while req_valid waits and cl_sel3
// changes only while idle.
module sdr_bank_seq
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int DQ_W   = 16,
    parameter int BURST  = 4,
    parameter int T_RCD  = 2,
    parameter int T_RC   = 9,
    parameter int T_RDL  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cl_sel3,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic [BURST*DQ_W-1:0] req_wdata,
    output logic                  ready,
    output logic [DQ_W-1:0]       rd_data,
    output logic                  rd_valid,
    output logic                  sd_cke,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [BANK_W-1:0]     sd_ba,
    output logic [ROW_W-1:0]      sd_addr,
    output logic [DQ_W/8-1:0]     sd_dqm,
    output logic [DQ_W-1:0]       sd_dq_out,
    output logic                  sd_dq_oe,
    input  logic [DQ_W-1:0]       sd_dq_in
);
    localparam int RC_AGE_MAX = T_RC + 1;
    localparam int RC_AGE_W   = $clog2(RC_AGE_MAX + 1);

    sdr_cmd_e cmd;
    logic     idle;
    logic     rc_done;
    logic     cap_busy;
    logic     rd_beat;
    logic     accept;

    assign ready  = idle & rc_done & ~cap_busy;
    assign accept = req_valid & ready;

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;
    assign sd_dqm = '0;

    sdr_seq_ctrl #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .DQ_W  (DQ_W),
        .BURST (BURST),
        .T_RCD (T_RCD),
        .T_RDL (T_RDL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_write(req_write),
        .req_bank (req_bank),
        .req_row  (req_row),
        .req_col  (req_col),
        .req_wdata(req_wdata),
        .cmd      (cmd),
        .addr     (sd_addr),
        .ba       (sd_ba),
        .dq_out   (sd_dq_out),
        .dq_oe    (sd_dq_oe),
        .rd_beat  (rd_beat),
        .idle     (idle)
    );

    sdr_gap_timer #(
        .LIMIT(T_RC)
    ) u_rc_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .done (rc_done)
    );

    sdr_rd_capture #(
        .DQ_W (DQ_W),
        .BURST(BURST)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_in (rd_beat),
        .cl3     (cl_sel3),
        .dq_in   (sd_dq_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .busy    (cap_busy)
    );

    // Checker state: cycles since the last activate, saturating.
    logic [RC_AGE_W-1:0] rc_age;
    logic                act_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_age   <= '0;
            act_seen <= 1'b0;
        end else if (cmd == CMD_ACT) begin
            rc_age   <= RC_AGE_W'(1);
            act_seen <= 1'b1;
        end else if (rc_age != RC_AGE_W'(RC_AGE_MAX)) begin
            rc_age <= rc_age + 1'b1;
        end
    end

    AST_RC_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && act_seen) |-> (rc_age >= RC_AGE_W'(T_RC)));  // R9

    AST_ACT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> $past(req_valid && ready));  // R8

    AST_NO_OE_WHILE_CAPTURING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sd_dq_oe);  // R6

endmodule

// File: tb/sim_sdr_bank_seq.sv
// Self-checking bench: a chain of read / write / read triples, covering
// every bank and both CAS latencies, against a behavioural memory model.
module sim_sdr_bank_seq;
    localparam int TB_RCD = 2;
    localparam int TB_RC  = 9;
    localparam int TB_RDL = 1;
    localparam int BL     = 4;
    localparam int WDOG   = 20000;

    typedef struct packed {
        logic        fresh;
        logic        w;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [8:0]  col;
        logic [63:0] wd;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cl_sel3 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [63:0] req_wdata = '0;
    logic        ready;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = '0;

    always #2 clk = ~clk;

    sdr_bank_seq #(
        .T_RCD(TB_RCD), .T_RC(TB_RC), .T_RDL(TB_RDL), .BURST(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cl_sel3(cl_sel3), .req_valid(req_valid),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int   cyc = 0;
    bit   tb_done = 1'b0;
    acc_t q_acc[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor state
    int          checks = 0;
    int          errors = 0;
    bit          rst_seen = 1'b0;
    logic [15:0] mem [int];
    int          exp_p[$];
    logic [15:0] exp_d[$];
    bit          drv_v [32];
    logic [15:0] drv_d [32];
    acc_t        cur;
    int          act_p = 0, col_p = 0, wr_c = -100;
    bit          prev_ok = 1'b0, prev_w = 1'b0;
    int          prev_l = 2;

    function automatic int key_of(logic [1:0] b, logic [12:0] r, logic [8:0] c);
        return int'({b, r, c});
    endfunction

    function automatic logic [15:0] mem_get(int k);
        if (mem.exists(k)) return mem[k];
        return 16'(k * 7 + 3) ^ 16'hA5A5;
    endfunction

    function automatic logic [8:0] col_beat(logic [8:0] c, int i);
        return {c[8:2], 2'(c[1:0] + 2'(i))};
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // All checks run here, on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cyc > WDOG) begin
            chk(1'b0, "watchdog", cyc, WDOG);
            finish_run();
        end
        // drive the memory's read word for this cycle
        sd_dq_in = drv_v[cyc % 32] ? drv_d[cyc % 32] : 16'h0;
        drv_v[cyc % 32] = 1'b0;
        if (rst_n) begin
            automatic logic [3:0] c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            automatic int lat = cl_sel3 ? 3 : 2;
            if (!rst_seen) begin
                rst_seen = 1'b1;
                chk(c == 4'b0111, "R10 reset cmd", c, 4'b0111);
                chk(ready == 1'b1, "R10 reset ready", ready, 1);
                chk(sd_dq_oe == 1'b0, "R10 reset oe", sd_dq_oe, 0);
                chk(rd_valid == 1'b0, "R10 reset rd_valid", rd_valid, 0);
            end
            chk(sd_cke == 1'b1 && sd_dqm == 2'b00, "R1 cke/dqm", {sd_cke, sd_dqm}, 3'b100);
            chk(c == 4'b0111 || c == 4'b0011 || c == 4'b0101 || c == 4'b0100 || c == 4'b0010,
                "R1 legal code", c, 4'b0111);
            if (c == 4'b0011) begin
                chk(q_acc.size() != 0, "R8 activate without request", q_acc.size(), 1);
                if (q_acc.size() != 0) cur = q_acc.pop_front();
                chk(sd_addr == cur.row, "R2 activate row", sd_addr, cur.row);
                chk(sd_ba == cur.bank, "R2 activate bank", sd_ba, cur.bank);
                if (prev_ok && !cur.fresh) begin
                    automatic int g = prev_w ? imax(TB_RC, TB_RCD + BL + TB_RDL + 1)
                                             : imax(TB_RC, imax(TB_RCD + BL + 2, TB_RCD + prev_l + BL + 1));
                    chk(cyc - act_p == g, "R9 activate gap", cyc - act_p, g);
                end
                act_p = cyc;
            end
            if (c == 4'b0101 || c == 4'b0100) begin
                chk((c == 4'b0100) == cur.w, "R2 column kind", c, cur.w);
                chk(cyc - act_p == TB_RCD, "R3 rcd", cyc - act_p, TB_RCD);
                chk(sd_addr[8:0] == cur.col && sd_addr[10] == 1'b0, "R3 column addr",
                    sd_addr, cur.col);
                chk(sd_ba == cur.bank, "R2 column bank", sd_ba, cur.bank);
                col_p = cyc;
                if (c == 4'b0100) wr_c = cyc;
                else begin
                    for (int i = 0; i < BL; i++) begin
                        automatic logic [15:0] d = mem_get(key_of(cur.bank, cur.row, col_beat(cur.col, i)));
                        drv_v[(cyc + lat + i) % 32] = 1'b1;
                        drv_d[(cyc + lat + i) % 32] = d;
                        exp_p.push_back(cyc + lat + i + 1);
                        exp_d.push_back(d);
                    end
                end
            end
            if (c == 4'b0010) begin
                automatic int g = cur.w ? (BL - 1 + TB_RDL) : BL;
                chk(sd_ba == cur.bank, "R2 precharge bank", sd_ba, cur.bank);
                chk(sd_addr[10] == 1'b0, "R4 precharge A10", sd_addr[10], 0);
                chk(cyc - col_p == g, cur.w ? "R5 write to precharge" : "R4 read to precharge",
                    cyc - col_p, g);
                prev_ok = 1'b1;
                prev_w  = cur.w;
                prev_l  = lat;
            end
            begin
                automatic bit exp_oe = (cyc >= wr_c) && (cyc < wr_c + BL);
                chk(sd_dq_oe == exp_oe, "R6 output enable", sd_dq_oe, exp_oe);
                if (exp_oe) begin
                    automatic int i = cyc - wr_c;
                    automatic logic [15:0] w = cur.wd[16*i +: 16];
                    chk(sd_dq_out == w, "R6 write beat", sd_dq_out, w);
                    mem[key_of(cur.bank, cur.row, col_beat(cur.col, i))] = sd_dq_out;
                end
            end
            if (rd_valid) begin
                chk(exp_p.size() != 0, "R7 unexpected rd_valid", cyc, 0);
                if (exp_p.size() != 0) begin
                    automatic int p = exp_p.pop_front();
                    automatic logic [15:0] d = exp_d.pop_front();
                    chk(p == cyc, "R7 read beat timing", cyc, p);
                    chk(rd_data == d, "R7 read beat data", rd_data, d);
                end
            end
            if (tb_done) begin
                chk(exp_p.size() == 0, "R7 missing read beats", exp_p.size(), 0);
                chk(q_acc.size() == 0, "R8 requests not served", q_acc.size(), 0);
                finish_run();
            end
        end
    end

    // Present one request and hold it until it is accepted.
    task automatic issue(input bit fresh, input bit w, input logic [1:0] b,
                         input logic [12:0] r, input logic [8:0] c, input logic [63:0] wd);
        acc_t a;
        a = '{fresh: fresh, w: w, bank: b, row: r, col: c, wd: wd};
        q_acc.push_back(a);
        req_valid = 1'b1;
        req_write = w;
        req_bank  = b;
        req_row   = r;
        req_col   = c;
        req_wdata = wd;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < 2; l++) begin
            cl_sel3 = l[0];
            for (int b = 0; b < 4; b++) begin
                for (int k = 0; k < 2; k++) begin
                    automatic logic [8:0]  c  = 9'(b * 8 + k * 5 + l * 2);
                    automatic logic [12:0] r  = 13'(b * 100 + k * 3 + l * 50 + 1);
                    automatic logic [63:0] wd;
                    for (int i = 0; i < 4; i++)
                        wd[16*i +: 16] = 16'(16'h5000 + b * 16'h1000 + k * 16'h100 + l * 16'h10 + i);
                    issue(b == 0 && k == 0, 1'b0, 2'(b), r, c, '0);  // read of untouched data
                    issue(1'b0, 1'b1, 2'(b), r, c, wd);              // read then write
                    issue(1'b0, 1'b0, 2'(b), r, c, '0);              // write then read back
                end
            end
            req_valid = 1'b0;
            repeat (30) @(negedge clk);
        end
        tb_done = 1'b1;
    end

endmodule